// File: doc/BRIEF.md
# Handle Position Stepper with Task Stack

This block is the first stage of a two-level address sequencer. For the scan task that is currently live, it steps a two-dimensional handle position across a rectangular data map in raster order. Two copies of one axis stepper produce the positions: one gives the column coordinate and one gives the row coordinate. Each task has read-only constants (start, step and limit per axis) and a base offset per axis. The block adds the base offset and a relative offset, given when the task is started, to the raw position. This lets several data maps share one memory without overlapping.

A downstream stage takes positions through a valid/ready handshake. A one-cycle done pulse follows the last position of a scan. An external runtime orders task switches. On a switch, the live values of the running task are written into its stack slot: column, row, both relative offsets, and whether it is still scanning. The selected task's values are then read back. This happens in two cycles, so interleaved or nested scans can share the stepper. Task constants are loaded through a narrow write port. Each write carries a field code: 0 column start, 1 column step, 2 column limit, 3 row start, 4 row step, 5 row limit, 6 column base, 7 row base.

Top module: `handle_stepper`

## Requirements
- R1: After reset, `out_valid` and `done` are low, task 0 is live, and every task and every constant is idle or zero.
- R2: A `start` accepted in a run cycle loads the live task's column and row start values and latches `start_rx`/`start_ry`. From the next cycle, `out_valid` is high and the first position is shown.
- R3: On every cycle with `out_valid` and `out_ready` both high, the column advances by its step. While `out_ready` is low, the position holds and `out_valid` stays high.
- R4: If column plus column step (unsigned, 17-bit) exceeds the column limit on a handshake, the column reloads its start value and the row advances by its step.
- R5: If the column wraps on a handshake and row plus row step exceeds the row limit, the scan ends. `out_valid` drops and `done` is high for exactly the following cycle.
- R6: `out_x` = column + relative column offset + column base, and `out_y` = row + relative row offset + row base, both modulo 2^16.
- R7: After an accepted `sw_req`, `out_valid` is low for exactly one cycle. Then the task chosen by `sw_task` is live. A task that was never started shows `out_valid` low.
- R8: A task that is switched out and later selected again resumes at the position it would have shown next. A handshake in the switch cycle counts toward that position.
- R9: `start` is ignored in a cycle with `sw_req` and in the cycle after an accepted switch. `sw_req` is also ignored in that cycle.
- R10: Writing the constants of one task, or running another task, leaves a switched-out task's saved state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Constant write strobe |
| cfg_task | input | 3 | Task whose constant is written |
| cfg_field | input | 3 | Field code (0..7, see above) |
| cfg_data | input | 16 | Constant value |
| sw_req | input | 1 | Switch command from the runtime |
| sw_task | input | 3 | Task to make live |
| start | input | 1 | Begin a scan of the live task |
| start_rx | input | 16 | Relative column offset for that scan |
| start_ry | input | 16 | Relative row offset for that scan |
| out_ready | input | 1 | Next stage accepts a position |
| out_valid | output | 1 | Position is valid |
| out_x | output | 16 | Column handle position |
| out_y | output | 16 | Row handle position |
| done | output | 1 | Pulse after the last position of a scan |

## Verification
A small hand-sized map (column 10..16 step 3, row 5..8 step 2) is scanned with `out_ready` held high, and then with `out_ready` low for a stretch. This separates a correct wrap point and end point from an off-by-one limit compare, and separates a true hold from a free-running stepper. Offsets near 2^16 show whether the sums wrap modulo 2^16. Switches are tested in several ways: to an idle task, back to a partly scanned one, with a handshake in the switch cycle, and with `start` colliding with a switch. These show whether the saved state is the post-handshake value and whether the stack keeps each slot intact. A long random run then mixes switches, starts, constant writes and ready patterns, and compares every cycle against a per-task reference model.

// File: rtl/hps_pkg.sv
// Shared types for the handle position stepper.
// Assumes positions and offsets share one width.
package hps_pkg;
    parameter int unsigned POS_W = 16;

    // Per-axis read-only scan constants
    typedef struct packed {
        logic [POS_W-1:0] start;
        logic [POS_W-1:0] step;
        logic [POS_W-1:0] limit;
    } axis_cfg_t;

    // Live values kept in a stack slot
    typedef struct packed {
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
        logic [POS_W-1:0] rx;
        logic [POS_W-1:0] ry;
        logic             act;
    } live_t;

    typedef enum logic {ST_RUN = 1'b0, ST_LOAD = 1'b1} sw_state_t;
endpackage

// File: rtl/hps_param_table.sv
// Holds per-task read-only constants, written one field at a time.
// Assumes the field code order: 0..2 column start/step/limit,
// 3..5 row start/step/limit, 6 column base, 7 row base.
module hps_param_table #(
    parameter int unsigned TASKS = 8,
    parameter int unsigned TW    = $clog2(TASKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [TW-1:0]            wtask,
    input  logic [2:0]               field,
    input  logic [hps_pkg::POS_W-1:0] wdata,
    input  logic [TW-1:0]            rtask,
    output hps_pkg::axis_cfg_t       cfg_x,
    output hps_pkg::axis_cfg_t       cfg_y,
    output logic [hps_pkg::POS_W-1:0] base_x,
    output logic [hps_pkg::POS_W-1:0] base_y
);
    localparam int unsigned NF = 8;
    logic [hps_pkg::POS_W-1:0] tbl [TASKS][NF];

    // Write one constant field of one task
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TASKS; t++)
                for (int f = 0; f < NF; f++)
                    tbl[t][f] <= '0;
        end else if (we) begin
            tbl[wtask][field] <= wdata;
        end
    end

    // Present the live task's constants
    always_comb begin
        cfg_x  = '{start: tbl[rtask][0], step: tbl[rtask][1], limit: tbl[rtask][2]};
        cfg_y  = '{start: tbl[rtask][3], step: tbl[rtask][4], limit: tbl[rtask][5]};
        base_x = tbl[rtask][6];
        base_y = tbl[rtask][7];
    end
endmodule

// File: rtl/hps_axis_step.sv
// One axis stepper: holds a position, reloads or restores it, or
// advances it by its step with wrap to start past the limit.
// Assumes restore beats restart, which beats advance.
module hps_axis_step (
    input  logic                      clk,
    input  logic                      rst_n,
    input  hps_pkg::axis_cfg_t        cfg,
    input  logic                      restore_en,
    input  logic [hps_pkg::POS_W-1:0] restore_val,
    input  logic                      restart,
    input  logic                      adv,
    output logic [hps_pkg::POS_W-1:0] pos,
    output logic [hps_pkg::POS_W-1:0] nxt,
    output logic                      last
);
    logic [hps_pkg::POS_W:0] sum;

    // Decide the next position and whether this step passes the limit
    always_comb begin
        sum  = {1'b0, pos} + {1'b0, cfg.step};
        last = sum > {1'b0, cfg.limit};
        if (restore_en)   nxt = restore_val;
        else if (restart) nxt = cfg.start;
        else if (adv)     nxt = last ? cfg.start : sum[hps_pkg::POS_W-1:0];
        else              nxt = pos;
    end

    // Position register
    always_ff @(posedge clk) begin
        if (!rst_n) pos <= '0;
        else        pos <= nxt;
    end
endmodule

// File: rtl/hps_task_stack.sv
// Slot store for the live values of every task: one write port
// for saving, one combinational read port for restoring.
module hps_task_stack #(
    parameter int unsigned TASKS = 8,
    parameter int unsigned TW    = $clog2(TASKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [TW-1:0]   widx,
    input  hps_pkg::live_t  wdata,
    input  logic [TW-1:0]   ridx,
    output hps_pkg::live_t  rdata
);
    hps_pkg::live_t slot [TASKS];

    // Save a task's live values into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TASKS; t++) slot[t] <= '0;
        end else if (we) begin
            slot[widx] <= wdata;
        end
    end

    // Read the slot being restored
    assign rdata = slot[ridx];
endmodule

// File: rtl/handle_stepper.sv
// Top: raster stepping of the live task's handle position with
// base and relative offsets, a valid/ready output, and a two-cycle
// save/restore task switch ordered from outside.
// Assumes constants of the live task are not rewritten mid-scan.
module handle_stepper #(
    parameter int unsigned TASKS = 8,
    parameter int unsigned PW    = hps_pkg::POS_W,
    parameter int unsigned TW    = $clog2(TASKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [TW-1:0] cfg_task,
    input  logic [2:0]    cfg_field,
    input  logic [PW-1:0] cfg_data,
    input  logic          sw_req,
    input  logic [TW-1:0] sw_task,
    input  logic          start,
    input  logic [PW-1:0] start_rx,
    input  logic [PW-1:0] start_ry,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [PW-1:0] out_x,
    output logic [PW-1:0] out_y,
    output logic          done
);
    import hps_pkg::*;

    sw_state_t    state;
    logic [TW-1:0] cur, pend;
    logic [PW-1:0] rx, ry, rx_n, ry_n, base_x, base_y;
    logic          act, act_n;
    logic          loading, hs, sw_acc, st_acc, fin;
    logic [PW-1:0] x_pos, y_pos, x_nxt, y_nxt;
    logic          x_last, y_last;
    axis_cfg_t     cfg_x, cfg_y;
    live_t         rd, wr;

    hps_param_table #(.TASKS(TASKS), .TW(TW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wtask(cfg_task),
        .field(cfg_field), .wdata(cfg_data), .rtask(cur),
        .cfg_x(cfg_x), .cfg_y(cfg_y), .base_x(base_x), .base_y(base_y)
    );

    hps_axis_step u_xstep (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_x), .restore_en(loading),
        .restore_val(rd.x), .restart(st_acc), .adv(hs),
        .pos(x_pos), .nxt(x_nxt), .last(x_last)
    );

    hps_axis_step u_ystep (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_y), .restore_en(loading),
        .restore_val(rd.y), .restart(st_acc), .adv(hs && x_last),
        .pos(y_pos), .nxt(y_nxt), .last(y_last)
    );

    hps_task_stack #(.TASKS(TASKS), .TW(TW)) u_stack (
        .clk(clk), .rst_n(rst_n), .we(sw_acc), .widx(cur),
        .wdata(wr), .ridx(pend), .rdata(rd)
    );

    // Command decode and handshake
    always_comb begin
        loading   = (state == ST_LOAD);
        out_valid = act && !loading;
        hs        = out_valid && out_ready;
        sw_acc    = sw_req && !loading;
        st_acc    = start && !loading && !sw_req;
        fin       = hs && x_last && y_last;
    end

    // Next live offsets and scan flag
    always_comb begin
        if (loading) begin
            rx_n = rd.rx; ry_n = rd.ry; act_n = rd.act;
        end else if (st_acc) begin
            rx_n = start_rx; ry_n = start_ry; act_n = 1'b1;
        end else begin
            rx_n = rx; ry_n = ry; act_n = act && !fin;
        end
        wr = '{x: x_nxt, y: y_nxt, rx: rx_n, ry: ry_n, act: act_n};
    end

    // Switch sequencing, live offsets and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN; cur <= '0; pend <= '0;
            rx <= '0; ry <= '0; act <= 1'b0; done <= 1'b0;
        end else begin
            rx <= rx_n; ry <= ry_n; act <= act_n; done <= fin;
            if (sw_acc) begin
                state <= ST_LOAD; pend <= sw_task;
            end else if (loading) begin
                state <= ST_RUN; cur <= pend;
            end
        end
    end

    // Offset adders
    assign out_x = x_pos + rx + base_x;
    assign out_y = y_pos + ry + base_y;
endmodule

// File: rtl/hps_chk.sv
// Checker for the handle stepper's handshake, switch gap and done pulse.
module hps_chk #(
    parameter int unsigned PW = hps_pkg::POS_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic [PW-1:0] out_x,
    input logic [PW-1:0] out_y,
    input logic          done,
    input logic          sw_req,
    input logic          start,
    input logic          cfg_we,
    input logic          loading
);
    // R3
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !sw_req && !start && !cfg_we
        |=> out_valid && $stable(out_x) && $stable(out_y));
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));
    // R7
    sw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req && !loading |=> !out_valid);
    // R7
    load_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !out_valid);
endmodule

bind handle_stepper hps_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .done(done), .sw_req(sw_req),
    .start(start), .cfg_we(cfg_we), .loading(loading)
);

// File: tb/sim_handle_stepper.sv
`timescale 1ns/1ps
module sim_handle_stepper;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_task = 0, cfg_field = 0, sw_task = 0;
    logic [15:0] cfg_data = 0, start_rx = 0, start_ry = 0;
    logic        sw_req = 0, start = 0, out_ready = 0;
    logic        out_valid, done;
    logic [15:0] out_x, out_y;

    int n_chk = 0, n_bad = 0;

    // reference model
    logic [15:0] m_cfg [8][8];
    logic [15:0] m_x [8], m_y [8], m_rx [8], m_ry [8];
    bit          m_act [8];
    int          m_cur = 0, m_pend = 0;
    bit          m_load = 0, m_done = 0;
    string       tag = "R3";

    handle_stepper u0 (.*);

    always #2.5 clk = ~clk;

    task automatic check(string t, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_x();
        return m_x[m_cur] + m_rx[m_cur] + m_cfg[m_cur][6];
    endfunction
    function automatic logic [15:0] exp_y();
        return m_y[m_cur] + m_ry[m_cur] + m_cfg[m_cur][7];
    endfunction

    task automatic compare();
        bit ev = !m_load && m_act[m_cur];
        check(m_load ? "R7" : tag, "valid", out_valid, ev);
        check(m_done ? "R5" : tag, "done", done, m_done);
        if (ev) begin
            check(tag, "x", out_x, exp_x());
            check(tag, "y", out_y, exp_y());
        end
    endtask

    // raster step of task t; returns 1 when the scan ends
    function automatic bit model_adv(int t);
        bit xl = ({1'b0, m_x[t]} + {1'b0, m_cfg[t][1]}) > {1'b0, m_cfg[t][2]};
        bit yl = ({1'b0, m_y[t]} + {1'b0, m_cfg[t][4]}) > {1'b0, m_cfg[t][5]};
        if (!xl) begin m_x[t] += m_cfg[t][1]; return 0; end
        m_x[t] = m_cfg[t][0];
        if (!yl) begin m_y[t] += m_cfg[t][4]; return 0; end
        m_y[t] = m_cfg[t][3];
        m_act[t] = 0;
        return 1;
    endfunction

    task automatic tick(bit sw, int swt, bit st, logic [15:0] srx, logic [15:0] sry, bit rdy);
        bit ev, nd;
        sw_req = sw; sw_task = swt[2:0]; start = st;
        start_rx = srx; start_ry = sry; out_ready = rdy;
        ev = !m_load && m_act[m_cur];
        nd = 0;
        if (m_load) begin
            m_cur = m_pend; m_load = 0;
        end else begin
            if (ev && rdy) nd = model_adv(m_cur);
            if (sw) begin m_pend = swt; m_load = 1; end
            else if (st) begin
                m_x[m_cur] = m_cfg[m_cur][0]; m_y[m_cur] = m_cfg[m_cur][3];
                m_rx[m_cur] = srx; m_ry[m_cur] = sry; m_act[m_cur] = 1;
            end
        end
        if (cfg_we) m_cfg[cfg_task][cfg_field] = cfg_data;
        m_done = nd;
        @(negedge clk);
        compare();
        cfg_we = 0; sw_req = 0; start = 0;
    endtask

    task automatic cfg_tick(int t, int f, logic [15:0] d);
        cfg_we = 1; cfg_task = t[2:0]; cfg_field = f[2:0]; cfg_data = d;
        tick(0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(int n, bit rdy);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, rdy);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] sx, sy;
        void'($urandom(32'd1234));
        for (int t = 0; t < 8; t++) begin
            m_x[t] = 0; m_y[t] = 0; m_rx[t] = 0; m_ry[t] = 0; m_act[t] = 0;
            for (int f = 0; f < 8; f++) m_cfg[t][f] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        check("R1", "valid", out_valid, 0);
        check("R1", "done", done, 0);

        // task 0: column 10..16 step 3, row 5..8 step 2, base 100/200
        cfg_tick(0, 0, 10); cfg_tick(0, 1, 3); cfg_tick(0, 2, 16);
        cfg_tick(0, 3, 5);  cfg_tick(0, 4, 2); cfg_tick(0, 5, 8);
        cfg_tick(0, 6, 100); cfg_tick(0, 7, 200);
        tag = "R2";
        tick(0, 0, 1, 1, 2, 0);
        check("R2", "first x", out_x, 111);
        check("R2", "first y", out_y, 207);
        tag = "R3";
        idle(3, 0);
        check("R3", "held x", out_x, 111);
        tick(0, 0, 0, 0, 0, 1);
        check("R3", "stepped x", out_x, 114);
        tag = "R4";
        idle(2, 1);
        check("R4", "wrap x", out_x, 111);
        check("R4", "row step y", out_y, 209);
        idle(3, 1);
        check("R5", "done pulse", done, 1);
        check("R5", "valid after end", out_valid, 0);
        idle(1, 1);
        check("R5", "done single", done, 0);

        // R6: offset sums wrap modulo 2^16
        cfg_tick(1, 2, 40); cfg_tick(1, 1, 1); cfg_tick(1, 4, 1); cfg_tick(1, 5, 3);
        cfg_tick(1, 6, 16'hFFF0); cfg_tick(1, 7, 16'hFFFF);
        tag = "R7";
        tick(1, 1, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0);
        tag = "R6";
        tick(0, 0, 1, 16'h0020, 16'h0003, 0);
        check("R6", "wrapped x", out_x, 16'h0010);
        check("R6", "wrapped y", out_y, 16'h0002);
        idle(4, 1);

        // R7/R8: switch to idle task 3, handshake in switch cycle, resume
        tag = "R8";
        sx = exp_x() + 1;
        tick(1, 3, 0, 0, 0, 1);
        check("R7", "gap valid", out_valid, 0);
        tick(0, 0, 0, 0, 0, 1);
        check("R7", "idle task valid", out_valid, 0);
        tick(1, 1, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0);
        check("R8", "resumed x", out_x, sx);

        // R9: start during switch and in the restore cycle is ignored
        tag = "R9";
        tick(1, 0, 1, 5, 5, 0);
        tick(0, 0, 1, 7, 7, 0);
        check("R9", "task0 stays idle", out_valid, 0);
        tick(1, 1, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0);
        check("R9", "task1 still valid", out_valid, 1);

        // R10: writing task 2 and running task 0 leave task 1 intact
        tag = "R10";
        sx = out_x; sy = out_y;
        tick(1, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0);
        cfg_tick(2, 0, 9); cfg_tick(1, 3, 77);
        tick(0, 0, 1, 0, 0, 1);
        idle(5, 1);
        tick(1, 1, 0, 0, 0, 1);
        tick(0, 0, 0, 0, 0, 0);
        check("R10", "task1 x kept", out_x, sx);
        check("R10", "task1 y kept", out_y, sy);

        // random mix
        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 4) begin
                tick(1, $urandom_range(0, 7), 0, 0, 0, $urandom_range(0, 1));
            end else if (r < 8) begin
                tick(0, 0, 1, 16'($urandom), 16'($urandom), $urandom_range(0, 1));
            end else if (r < 12) begin
                int t = $urandom_range(0, 7);
                int f = $urandom_range(0, 7);
                logic [15:0] d;
                if (t == m_cur || (m_load && t == m_pend)) t = (t + 1) % 8;
                if (t == m_cur || (m_load && t == m_pend)) t = (t + 1) % 8;
                d = (f == 1 || f == 4) ? 16'($urandom_range(1, 5)) :
                    (f == 6 || f == 7) ? 16'($urandom) : 16'($urandom_range(0, 20));
                cfg_tick(t, f, d);
            end else begin
                tick(0, 0, 0, 0, 0, $urandom_range(0, 3) != 0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule